// File: doc/BRIEF.md
# Supply-Loss Write Guard and Backup-Source Sequencer

This block holds the digital decision logic that sits beside a battery-backed static memory. A measuring circuit outside the block delivers a supply reading in millivolts together with a valid strobe. From that stream the block decides four things: whether writes into the memory are blocked, whether the memory bus is isolated, whether the memory is powered from the backup cell, and whether the memory is ready for normal use.

A four-state machine follows the supply down and back up. The states are normal, guarded, on-battery and recovering. Three thresholds are used, and they are parameters: a fail-detect level at 4370 mV, a full-operation level at 4500 mV and a source-switch level at 3000 mV. Because the falling and rising paths use different levels, the steps always happen in a fixed order. Going down, the block first guards the bus and then switches to the battery. Coming up, it first switches back to the main supply and only later releases the guard. The gap between 4370 and 4500 mV gives hysteresis around the normal state.

A threshold crossing is acted on only after a run of agreeing valid samples. Samples without the strobe are skipped. The backup cell stays disconnected until the supply has reached the normal state once after reset.

Top module: `pfs_supervisor`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, the outputs are `wr_block`=1, `bus_iso`=1, `bat_sel`=0 and `pwr_ok`=0. Reset places the machine in the on-battery state with the backup connection not yet enabled.
- R2: A crossing condition is acted on only when QUAL (4) consecutive valid samples meet it. One valid sample that does not meet the condition restarts the run. The outputs change at the clock edge that takes the qualifying sample.
- R3: A cycle with `smp_vld`=0 is ignored. It does not advance or clear any run, and it does not change any output.
- R4: From normal, a qualified run of readings strictly below TH_PFD (4370) enters the guarded state. A reading equal to TH_PFD does not count toward that run.
- R5: In every state other than normal, `wr_block` and `bus_iso` are both 1 and `pwr_ok` is 0. In the normal state the outputs are `wr_block`=0, `bus_iso`=0, `bat_sel`=0 and `pwr_ok`=1.
- R6: From guarded or recovering, a qualified run of readings strictly below TH_SW (3000) enters on-battery. There `bat_sel`=1 if the backup connection is enabled. A reading of exactly 3000 does not count toward that run.
- R7: From on-battery, a qualified run of readings strictly above TH_SW enters recovering. There `bat_sel`=0 while the guard stays on.
- R8: Only a qualified run of readings strictly above TH_OK (4500) returns the block to normal, and only from guarded or recovering. A reading of exactly 4500 does not count toward that run. Readings between 4370 and 4500 leave the normal state unchanged.
- R9: From recovering, a qualified run of readings below TH_SW returns the block to on-battery.
- R10: `bat_sel` stays 0 until the normal state has been reached at least once since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vsup_mv | input | VW (13) | Supply reading in millivolts |
| smp_vld | input | 1 | Marks `vsup_mv` as a fresh sample this cycle |
| wr_block | output | 1 | Blocks all writes to the memory |
| bus_iso | output | 1 | Masks memory inputs and floats memory data outputs |
| bat_sel | output | 1 | 1 = memory powered from the backup cell, 0 = main supply |
| pwr_ok | output | 1 | Memory is in full read/write operation |

## Verification
The bench drives readings that sit exactly on each threshold. A design that used non-strict compares would then guard at 4370 mV, release at 4500 mV or switch source at 3000 mV, and each of these shows up as an early output change. The bench breaks a run of agreeing samples with a single disagreeing one, and inserts samples without the strobe inside a run. A design that failed to restart the run would change state one sample early. A design that counted or cleared on unstrobed cycles would change state one sample late or early. The bench also drops the supply right after reset, before normal has ever been reached, and expects `bat_sel` to stay 0. It then checks that a deep drop later connects the battery, and that the rise back goes through recovering, so the guard is never released at 3000 mV.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_GUARD  = 2'd1,
    ST_BATT   = 2'd2,
    ST_RECOV  = 2'd3
  } pfs_state_e;

  // indexes of the crossing conditions
  localparam int C_BELOW_PFD = 0;
  localparam int C_BELOW_SW  = 1;
  localparam int C_ABOVE_SW  = 2;
  localparam int C_ABOVE_OK  = 3;
  localparam int NCOND       = 4;

endpackage

// File: rtl/pfs_qual.sv
// Counts consecutive valid samples that meet one condition; saturates at QUAL.
module pfs_qual #(
  parameter int QUAL = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_vld,
  input  logic cond,
  output logic agree
);
  localparam int CW = $clog2(QUAL + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL - 1);
  localparam logic [CW-1:0] FULL = CW'(QUAL);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (smp_vld) begin
      if (!cond)
        run_q <= '0;
      else if (run_q != FULL)
        run_q <= run_q + 1'b1;
    end
  end

  // the current sample completes (or extends) a qualifying run
  assign agree = smp_vld && cond && (run_q >= LAST);
endmodule

// File: rtl/pfs_fsm.sv
module pfs_fsm
  import pfs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NCOND-1:0] hit,
  output logic             wr_block,
  output logic             bus_iso,
  output logic             bat_sel,
  output logic             pwr_ok
);
  pfs_state_e st_q, st_d;
  logic       armed_q, armed_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_NORMAL: if (hit[C_BELOW_PFD]) st_d = ST_GUARD;
      ST_GUARD: begin
        if (hit[C_BELOW_SW])      st_d = ST_BATT;
        else if (hit[C_ABOVE_OK]) st_d = ST_NORMAL;
      end
      ST_BATT:  if (hit[C_ABOVE_SW]) st_d = ST_RECOV;
      ST_RECOV: begin
        if (hit[C_BELOW_SW])      st_d = ST_BATT;
        else if (hit[C_ABOVE_OK]) st_d = ST_NORMAL;
      end
      default: st_d = ST_BATT;
    endcase
    armed_d = armed_q || (st_d == ST_NORMAL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_BATT;
      armed_q  <= 1'b0;
      wr_block <= 1'b1;
      bus_iso  <= 1'b1;
      bat_sel  <= 1'b0;
      pwr_ok   <= 1'b0;
    end else begin
      st_q     <= st_d;
      armed_q  <= armed_d;
      wr_block <= (st_d != ST_NORMAL);
      bus_iso  <= (st_d != ST_NORMAL);
      bat_sel  <= (st_d == ST_BATT) && armed_d;
      pwr_ok   <= (st_d == ST_NORMAL);
    end
  end
endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor
  import pfs_pkg::*;
#(
  parameter int VW     = 13,
  parameter int TH_PFD = 4370,
  parameter int TH_OK  = 4500,
  parameter int TH_SW  = 3000,
  parameter int QUAL   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [VW-1:0] vsup_mv,
  input  logic          smp_vld,
  output logic          wr_block,
  output logic          bus_iso,
  output logic          bat_sel,
  output logic          pwr_ok
);
  localparam logic [VW-1:0] PFD_L = VW'(TH_PFD);
  localparam logic [VW-1:0] OK_L  = VW'(TH_OK);
  localparam logic [VW-1:0] SW_L  = VW'(TH_SW);

  logic [NCOND-1:0] cond;
  logic [NCOND-1:0] hit;

  always_comb begin
    cond              = '0;
    cond[C_BELOW_PFD] = (vsup_mv < PFD_L);
    cond[C_BELOW_SW]  = (vsup_mv < SW_L);
    cond[C_ABOVE_SW]  = (vsup_mv > SW_L);
    cond[C_ABOVE_OK]  = (vsup_mv > OK_L);
  end

  for (genvar g = 0; g < NCOND; g++) begin : g_qual
    pfs_qual #(.QUAL(QUAL)) qual_i (
      .clk     (clk),
      .rst     (rst),
      .smp_vld (smp_vld),
      .cond    (cond[g]),
      .agree   (hit[g])
    );
  end

  pfs_fsm fsm_i (
    .clk      (clk),
    .rst      (rst),
    .hit      (hit),
    .wr_block (wr_block),
    .bus_iso  (bus_iso),
    .bat_sel  (bat_sel),
    .pwr_ok   (pwr_ok)
  );
endmodule

// File: rtl/pfs_supervisor_chk.sv
module pfs_supervisor_chk #(
  parameter int VW     = 13,
  parameter int TH_PFD = 4370,
  parameter int TH_OK  = 4500
) (
  input logic          clk,
  input logic          rst,
  input logic [VW-1:0] vsup_mv,
  input logic          smp_vld,
  input logic          wr_block,
  input logic          bus_iso,
  input logic          bat_sel,
  input logic          pwr_ok
);
  logic seen_ok_q;

  always_ff @(posedge clk) begin
    if (rst) seen_ok_q <= 1'b0;
    else if (pwr_ok) seen_ok_q <= 1'b1;
  end

  a_r5_ready_means_open: assert property (@(posedge clk) disable iff (rst)
    pwr_ok |-> (!wr_block && !bus_iso && !bat_sel));

  a_r6_battery_only_guarded: assert property (@(posedge clk) disable iff (rst)
    bat_sel |-> (wr_block && bus_iso && !pwr_ok));

  a_r3_idle_holds_outputs: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> ($stable(wr_block) && $stable(bus_iso) && $stable(bat_sel) && $stable(pwr_ok)));

  a_r10_no_battery_unarmed: assert property (@(posedge clk) disable iff (rst)
    !seen_ok_q |-> !bat_sel);

  a_r8_ready_needs_high: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_ok) |-> $past(smp_vld && (int'(vsup_mv) > TH_OK)));

  a_r4_guard_needs_low: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_block) |-> $past(smp_vld && (int'(vsup_mv) < TH_PFD)));
endmodule

bind pfs_supervisor pfs_supervisor_chk #(.VW(VW), .TH_PFD(TH_PFD), .TH_OK(TH_OK)) chk_i (
  .clk(clk), .rst(rst), .vsup_mv(vsup_mv), .smp_vld(smp_vld),
  .wr_block(wr_block), .bus_iso(bus_iso), .bat_sel(bat_sel), .pwr_ok(pwr_ok)
);

// File: tb/pfs_supervisor_tb_top.sv
`timescale 1ns/1ps
module pfs_supervisor_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] vsup_mv = '0;
  logic        smp_vld = 1'b0;
  logic        wr_block, bus_iso, bat_sel, pwr_ok;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk; // 125 MHz

  pfs_supervisor dut_i (
    .clk(clk), .rst(rst), .vsup_mv(vsup_mv), .smp_vld(smp_vld),
    .wr_block(wr_block), .bus_iso(bus_iso), .bat_sel(bat_sel), .pwr_ok(pwr_ok)
  );

  // {mv, vld, requirement, expected {wr_block, bus_iso, bat_sel, pwr_ok}} after the edge
  localparam int NV = 54;
  localparam logic [21:0] VEC [NV] = '{
    {13'd3500,1'b1,4'd7,4'b1100}, {13'd3500,1'b1,4'd7,4'b1100}, {13'd3500,1'b1,4'd7,4'b1100},
    {13'd3500,1'b1,4'd7,4'b1100},                                   // R7 into recovering
    {13'd4600,1'b1,4'd8,4'b1100}, {13'd4600,1'b1,4'd8,4'b1100}, {13'd4600,1'b1,4'd8,4'b1100},
    {13'd4600,1'b1,4'd8,4'b0001},                                   // R8 normal
    {13'd4400,1'b1,4'd4,4'b0001}, {13'd4400,1'b1,4'd4,4'b0001}, {13'd4400,1'b1,4'd4,4'b0001},
    {13'd4400,1'b1,4'd4,4'b0001},                                   // R4 hysteresis band
    {13'd4370,1'b1,4'd4,4'b0001}, {13'd4370,1'b1,4'd4,4'b0001}, {13'd4370,1'b1,4'd4,4'b0001},
    {13'd4370,1'b1,4'd4,4'b0001},                                   // R4 equal is not below
    {13'd4369,1'b1,4'd2,4'b0001}, {13'd4369,1'b1,4'd2,4'b0001}, {13'd4369,1'b1,4'd2,4'b0001},
    {13'd5000,1'b0,4'd3,4'b0001},                                   // R3 unstrobed
    {13'd4369,1'b1,4'd2,4'b1100},                                   // R2 fourth valid sample
    {13'd4501,1'b1,4'd8,4'b1100}, {13'd4501,1'b1,4'd8,4'b1100}, {13'd4501,1'b1,4'd8,4'b1100},
    {13'd4400,1'b1,4'd2,4'b1100},                                   // R2 run broken
    {13'd4501,1'b1,4'd2,4'b1100}, {13'd4501,1'b1,4'd2,4'b1100}, {13'd4501,1'b1,4'd2,4'b1100},
    {13'd4501,1'b1,4'd8,4'b0001},
    {13'd4000,1'b1,4'd4,4'b0001}, {13'd4000,1'b1,4'd4,4'b0001}, {13'd4000,1'b1,4'd4,4'b0001},
    {13'd4000,1'b1,4'd4,4'b1100},
    {13'd2999,1'b1,4'd6,4'b1100}, {13'd2999,1'b1,4'd6,4'b1100}, {13'd2999,1'b1,4'd6,4'b1100},
    {13'd2999,1'b1,4'd6,4'b1110},                                   // R6 on battery, armed
    {13'd3000,1'b1,4'd6,4'b1110}, {13'd3000,1'b1,4'd6,4'b1110}, {13'd3000,1'b1,4'd6,4'b1110},
    {13'd3000,1'b1,4'd6,4'b1110},
    {13'd3001,1'b1,4'd7,4'b1110}, {13'd3001,1'b1,4'd7,4'b1110}, {13'd3001,1'b1,4'd7,4'b1110},
    {13'd3001,1'b1,4'd7,4'b1100},
    {13'd2900,1'b1,4'd9,4'b1100}, {13'd2900,1'b1,4'd9,4'b1100}, {13'd2900,1'b1,4'd9,4'b1100},
    {13'd2900,1'b1,4'd9,4'b1110},                                   // R9 back to battery
    {13'd4600,1'b1,4'd7,4'b1110}, {13'd4600,1'b1,4'd7,4'b1110}, {13'd4600,1'b1,4'd7,4'b1110},
    {13'd4600,1'b1,4'd7,4'b1100},
    {13'd4600,1'b1,4'd8,4'b0001}
  };

  task automatic chk(input logic [3:0] exp, input string req);
    logic [3:0] act;
    act = {wr_block, bus_iso, bat_sel, pwr_ok};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // present one sample after a falling edge, let the rising edge take it, look at the next falling edge
  task automatic step(input logic [12:0] mv, input logic vld);
    vsup_mv = mv;
    smp_vld = vld;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(4'b1100, "R1 during reset");
    rst = 1'b0;
    @(negedge clk);
    chk(4'b1100, "R1 after reset");

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][21:9], VEC[i][8]);
      chk(VEC[i][3:0], $sformatf("R%0d vector %0d", VEC[i][7:4], i));
    end

    // R1: reset from normal
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(4'b1100, "R1 reset from normal");

    // R10: deep drop before normal was reached keeps the cell disconnected
    for (int i = 0; i < 4; i++) step(13'd2000, 1'b1);
    chk(4'b1100, "R10 unarmed low supply");
    for (int i = 0; i < 4; i++) step(13'd3500, 1'b1);
    for (int i = 0; i < 4; i++) step(13'd2000, 1'b1);
    chk(4'b1100, "R10 unarmed return to battery state");
    for (int i = 0; i < 5; i++) step(13'd4600, 1'b1);
    chk(4'b0001, "R8 normal after recovering");
    for (int i = 0; i < 4; i++) step(13'd2000, 1'b1);
    chk(4'b1100, "R4 guard first on fast drop");
    step(13'd2000, 1'b1);
    chk(4'b1110, "R6 battery after guard, armed");
    // R3: long unstrobed stretch with a high reading
    for (int i = 0; i < 10; i++) step(13'd5000, 1'b0);
    chk(4'b1110, "R3 unstrobed samples ignored");
    step(13'd5000, 1'b1);
    chk(4'b1110, "R2 single sample not enough");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule